// File: doc/BRIEF.md
# Sequential Byte Multiplier and Divider

This unit performs either an unsigned multiplication or an unsigned division of two byte operands, one step group per clock, and finishes in a fixed number of clocks. A one-clock request carries the operation code and both operands. The same clock edge that accepts the request also performs the first step group. Once the last step group is done, a one-clock completion strobe appears together with two result bytes and two flags.

A multiply returns the 16-bit product split into two bytes. The result byte that takes the place of the first operand holds the low half. The result byte that takes the place of the second operand holds the high half. A divide returns the quotient in the first result byte and the remainder in the second. The carry flag is always cleared. The overflow flag reports a product wider than one byte, or a division by zero. The unit is meant to sit beside an accumulator-style register pair. The surrounding pipeline issues a request and writes both result bytes back when the strobe arrives.

Top module: `muldiv8_seq`

## Requirements
- R1: With `op_i` = 0 (multiply), at completion `{res_b_o, res_a_o}` equals `opa_i * opb_i` taken as unsigned numbers, with `res_b_o` as the high byte.
- R2: With `op_i` = 1 (divide) and a non-zero `opb_i`, at completion `res_a_o` equals `opa_i / opb_i` and `res_b_o` equals `opa_i % opb_i`.
- R3: At the completion of a multiply, `carry_o` is 0 and `ovf_o` is 1 exactly when the product is greater than 255.
- R4: At the completion of a divide, `carry_o` is 0 and `ovf_o` is 1 exactly when `opb_i` was 0. Both result bytes are unspecified in the zero case.
- R5: A request that is accepted at clock edge k makes `done_o` high during exactly one cycle, the cycle that follows edge k+3 (four edges, counting the accepting edge).
- R6: `busy_o` is high from the accepting edge until the edge that raises `done_o`. During the completion cycle it is low, and a new request may be accepted at the next edge.
- R7: A request made while `busy_o` is high is ignored. The running operation keeps its operands, its timing and its result, and no additional completion follows.
- R8: `res_a_o`, `res_b_o`, `carry_o` and `ovf_o` keep their values between completions.
- R9: While reset is held low, `busy_o`, `done_o`, both result bytes and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only while idle |
| op_i | input | 1 | Operation code: 0 multiply, 1 divide |
| opa_i | input | 8 | First operand (multiplicand or dividend) |
| opb_i | input | 8 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| res_a_o | output | 8 | Low product byte or quotient |
| res_b_o | output | 8 | High product byte or remainder |
| carry_o | output | 1 | Carry flag, cleared by both operations |
| ovf_o | output | 1 | Overflow flag: wide product or zero divisor |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of a running operation. It carries different operands and the other operation code, so it would corrupt the result if it were ever taken. The stimulus raises it one cycle after an accepted request, then checks the original product and the absence of a second strobe. Back-to-back issue is exercised by placing every new request in the completion cycle of the previous one. The operand sweep covers every first operand against a dense set of second operands, which includes zero, one and 255.

// File: rtl/muldiv8_pkg.sv
package muldiv8_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

endpackage

// File: rtl/md_mul_stage.sv
// One shift-and-add multiply step on a combined product/multiplier register.
module md_mul_stage #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] pw_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] pw_o
);

    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, pw_i[2*W-1:W]} + (pw_i[0] ? {1'b0, mcand_i} : {(W+1){1'b0}});
        pw_o = {sum, pw_i[W-1:1]};
    end

endmodule

// File: rtl/md_div_stage.sv
// One restoring-division step: shift in a dividend bit, trial subtract.
module md_div_stage #(
    parameter int W = 8
) (
    input  logic [W:0]   rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W:0]   rem_o,
    output logic [W-1:0] quo_o
);

    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {rem_i[W-1:0], quo_i[W-1]};
        diff    = shifted - {1'b0, dvs_i};
        fits    = ~diff[W];
        rem_o   = fits ? diff : shifted;
        quo_o   = {quo_i[W-2:0], fits};
    end

endmodule

// File: rtl/md_seq_ctrl.sv
// Step sequencer: accepts a request when idle, counts CYCLES step edges.
module md_seq_ctrl #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  load, last;

    always_comb begin
        load = start_i && !st_q.busy;
        last = st_q.busy && (st_q.cnt == LAST_CNT);
        st_d      = st_q;
        st_d.done = last;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(1);
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (last) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o = load;
    assign step_o = load || st_q.busy;
    assign last_o = last;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != LAST_CNT) |=> st_q.busy); // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && $past(st_q.busy))); // R6

endmodule

// File: rtl/muldiv8_seq.sv
// Multi-cycle unsigned multiply/divide of two bytes with split results.
module muldiv8_seq
    import muldiv8_pkg::*;
#(
    parameter int W      = 8,
    parameter int CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] res_a_o,
    output logic [W-1:0] res_b_o,
    output logic         carry_o,
    output logic         ovf_o
);

    localparam int STEPS = W / CYCLES;
    localparam int CW    = $clog2(CYCLES + 1);

    typedef struct packed {
        md_op_e         op;
        logic [2*W-1:0] pw;
        logic [W-1:0]   mcand;
        logic [W:0]     rem;
        logic [W-1:0]   quo;
        logic [W-1:0]   dvs;
        logic [W-1:0]   res_a;
        logic [W-1:0]   res_b;
        logic           cy;
        logic           ov;
    } dp_t;

    dp_t  st_d, st_q;
    logic load, step, last;

    md_seq_ctrl #(.CYCLES(CYCLES)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .load_o (load),
        .step_o (step),
        .last_o (last),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    // Step inputs: fresh operands on the accepting edge, held state after.
    logic [2*W-1:0] mul_pw  [STEPS+1];
    logic [W:0]     div_rem [STEPS+1];
    logic [W-1:0]   div_quo [STEPS+1];
    logic [W-1:0]   mcand_in, dvs_in;

    always_comb begin
        mul_pw[0]  = load ? {{W{1'b0}}, opa_i} : st_q.pw;
        mcand_in   = load ? opb_i : st_q.mcand;
        div_rem[0] = load ? {(W+1){1'b0}} : st_q.rem;
        div_quo[0] = load ? opa_i : st_q.quo;
        dvs_in     = load ? opb_i : st_q.dvs;
    end

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        md_mul_stage #(.W(W)) mul_i (
            .pw_i   (mul_pw[g]),
            .mcand_i(mcand_in),
            .pw_o   (mul_pw[g+1])
        );
        md_div_stage #(.W(W)) div_i (
            .rem_i(div_rem[g]),
            .quo_i(div_quo[g]),
            .dvs_i(dvs_in),
            .rem_o(div_rem[g+1]),
            .quo_o(div_quo[g+1])
        );
    end

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.op    = load ? md_op_e'(op_i) : st_q.op;
            st_d.pw    = mul_pw[STEPS];
            st_d.mcand = mcand_in;
            st_d.rem   = div_rem[STEPS];
            st_d.quo   = div_quo[STEPS];
            st_d.dvs   = dvs_in;
        end
        if (last) begin
            st_d.cy = 1'b0;
            if (st_q.op == OP_DIV) begin
                st_d.res_a = div_quo[STEPS];
                st_d.res_b = div_rem[STEPS][W-1:0];
                st_d.ov    = (st_q.dvs == '0);
            end else begin
                st_d.res_a = mul_pw[STEPS][W-1:0];
                st_d.res_b = mul_pw[STEPS][2*W-1:W];
                st_d.ov    = |mul_pw[STEPS][2*W-1:W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_a_o = st_q.res_a;
    assign res_b_o = st_q.res_b;
    assign carry_o = st_q.cy;
    assign ovf_o   = st_q.ov;

    // Independent latency tracker used only by the assertions below.
    logic [CW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 lat_q <= '0;
        else if (load)                              lat_q <= CW'(1);
        else if (lat_q != '0 && lat_q < CW'(CYCLES)) lat_q <= lat_q + CW'(1);
        else                                        lat_q <= '0;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == CW'(CYCLES))); // R5
    AST_MUL_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.op == OP_MUL) |-> (ovf_o == (res_b_o != '0))); // R3
    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.op == OP_DIV && st_q.dvs != '0) |-> (res_b_o < st_q.dvs)); // R2
    AST_DIV_ZERO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.op == OP_DIV && st_q.dvs == '0) |-> ovf_o); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(res_a_o) && $stable(res_b_o) && $stable(ovf_o))); // R8

endmodule

// File: tb/muldiv8_seq_tb_top.sv
module muldiv8_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic       busy, done, cy, ov;
    logic [7:0] ra, rb;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv8_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .opa_i(a), .opb_i(b), .busy_o(busy), .done_o(done),
        .res_a_o(ra), .res_b_o(rb), .carry_o(cy), .ovf_o(ov)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_result(input bit o, input int x, input int y);
        if (!o) begin
            int p = x * y;
            chk("R1 low byte", int'(ra), p % 256);
            chk("R1 high byte", int'(rb), p / 256);
            chk("R3 overflow", int'(ov), int'(p > 255));
            chk("R3 carry", int'(cy), 0);
        end else begin
            if (y != 0) begin
                chk("R2 quotient", int'(ra), x / y);
                chk("R2 remainder", int'(rb), x % y);
            end
            chk("R4 overflow", int'(ov), int'(y == 0));
            chk("R4 carry", int'(cy), 0);
        end
    endtask

    // Entered at a negedge; returns at the negedge of the completion cycle.
    task automatic run_op(input bit o, input int x, input int y);
        start = 1'b1; op = o; a = 8'(x); b = 8'(y);
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after accept", int'(busy), 1);
        chk("R5 no early done", int'(done), 0);
        repeat (LAT - 2) @(negedge clk);
        chk("R6 busy mid-operation", int'(busy), 1);
        @(negedge clk);
        chk("R5 done at latency", int'(done), 1);
        chk("R6 idle at completion", int'(busy), 0);
        check_result(o, x, y);
    endtask

    function automatic int next_b(input int y);
        return (y < 16 || y >= 250) ? y + 1 : y + 5;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] ha, hb;
        repeat (3) @(negedge clk);
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset res_a", int'(ra), 0);
        chk("R9 reset res_b", int'(rb), 0);
        chk("R9 reset flags", int'({cy, ov}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_op(1'b0, 255, 255);
        run_op(1'b0, 0, 200);
        run_op(1'b0, 15, 17);
        run_op(1'b1, 255, 1);
        run_op(1'b1, 5, 9);
        run_op(1'b1, 7, 0);
        run_op(1'b1, 255, 255);

        // R7: second request while busy, different op and operands
        start = 1'b1; op = 1'b0; a = 8'd3; b = 8'd5;
        @(negedge clk);
        start = 1'b1; op = 1'b1; a = 8'd200; b = 8'd7;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R7 no early done", int'(done), 0);
        @(negedge clk);
        chk("R7 done at original time", int'(done), 1);
        chk("R7 result of first request", int'(ra), 15);
        chk("R7 high byte of first request", int'(rb), 0);
        chk("R7 overflow of first request", int'(ov), 0);
        @(negedge clk);
        chk("R7 no second completion", int'(done), 0);
        chk("R7 not restarted", int'(busy), 0);

        // R8: results hold while idle
        run_op(1'b0, 200, 100);
        ha = ra; hb = rb;
        a = 8'd1; b = 8'd1; op = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 res_a held", int'(ra), int'(ha));
        chk("R8 res_b held", int'(rb), int'(hb));
        chk("R8 overflow held", int'(ov), 1);
        chk("R8 no spurious done", int'(done), 0);

        // Sweep: every first operand against a dense second-operand set,
        // issued back to back.
        for (int o = 0; o < 2; o++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y = next_b(y)) begin
                    run_op(o[0], x, y);
                end
            end
        end

        @(negedge clk);
        finish_run();
    end

endmodule